// File: doc/BRIEF.md
# Atomic compare-and-swap memory unit

This unit carries out a single compare-and-swap on a single-port synchronous memory. A decoded request gives the access size, the acquire and release bits, the compare-register index and the base-register index, and the fixed field that must be all ones. It also gives the compare value, the new value, the byte address and a flag that enables the stack-pointer alignment check. The unit reads the addressed 32-bit or 64-bit item and compares it with the compare value. Only when the two are equal does it write the new value back. A bus lock is held from the read through the write, or through the compare when nothing is written, so that no other master can change the location in between.

The response returns the old value, zero-extended to the register width. It also carries the index of the register that receives it, a register write-enable, and the ordering and tag-check flags that the pipeline needs. Malformed, misaligned or badly aligned stack-pointer requests end in an abort. An abort touches no memory and clears the write-enable, so the compare register keeps its earlier contents.

The unit takes one request at a time. `req_ready` is high only while the unit is idle.

Top module: `cas_unit`

## Requirements
- R1: After reset, req_ready is 1 and rsp_done, bus_lock and mem_req are 0.
- R2: A request accepted without fault reads memory word req_addr[ADDR_W-1:3] in the cycle after acceptance. mem_rdata is taken one cycle after the read cycle.
- R3: Size 2'b11 is a 64-bit access and compares the whole word. Size 2'b10 is a 32-bit access: req_addr[2] picks the lane (0 selects bits 31:0, 1 selects bits 63:32), and only bits 31:0 of req_cmp and req_new are used.
- R4: On equality there is exactly one write to the same word, with byte mask bits set only for the accessed bytes. Counting the accepting clock edge as edge 0, rsp_done rises on edge 3 and is high for one cycle.
- R5: On inequality there is no memory write, and rsp_done rises on edge 2.
- R6: On a completed access, rsp_data is the old memory value zero-extended to 64 bits, rsp_we is 1 and rsp_reg equals req_rs. This holds whether the compare passes or fails.
- R7: bus_lock is high from the read cycle through the write cycle, or through the compare cycle when the compare fails. req_ready is 0 whenever bus_lock is 1.
- R8: rsp_acquire is 1 exactly when req_acq_bit is 1 and req_rs is not 31. rsp_release equals req_rel_bit.
- R9: rsp_tagchk is 1 exactly when req_rn is not 31.
- R10: An address that is not a multiple of the access size aborts the request. rsp_done and rsp_abort then rise on edge 0 with rsp_we 0 and rsp_data 0, and no memory access is made.
- R11: When req_rn is 31 and req_sp_chk is 1, an address with any of bits 3:0 set aborts the request. If req_rn is not 31, or req_sp_chk is 0, this check does not apply.
- R12: A request with req_rt2 not equal to 5'b11111, or with req_size[1] equal to 0, aborts as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_size | input | 2 | Access size code (10 = 32-bit, 11 = 64-bit) |
| req_acq_bit | input | 1 | Acquire bit of the encoding |
| req_rel_bit | input | 1 | Release bit of the encoding |
| req_rs | input | 5 | Compare and result register index |
| req_rn | input | 5 | Base register index, 31 = stack pointer |
| req_rt2 | input | 5 | Fixed field, must be all ones |
| req_addr | input | ADDR_W | Byte address from the base register or stack pointer |
| req_sp_chk | input | 1 | Stack-pointer alignment check enabled |
| req_cmp | input | DATA_W | Compare value |
| req_new | input | DATA_W | Value stored on a match |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W-3 | Memory word index |
| mem_wdata | output | DATA_W | Write data |
| mem_wmask | output | DATA_W/8 | Byte write mask |
| mem_rdata | input | DATA_W | Read data, one cycle after the read |
| bus_lock | output | 1 | Location locked against other masters |
| rsp_done | output | 1 | Response valid for one cycle |
| rsp_abort | output | 1 | Response is an abort |
| rsp_we | output | 1 | Write rsp_data into register rsp_reg |
| rsp_reg | output | 5 | Destination register index |
| rsp_data | output | DATA_W | Old value, zero-extended |
| rsp_acquire | output | 1 | Acquire ordering applies |
| rsp_release | output | 1 | Release ordering applies |
| rsp_tagchk | output | 1 | Tag check applies |

## Verification
Response timing depends on the outcome, counted from the accepting edge: an abort answers on edge 0, a failed compare on edge 2 and a successful one on edge 3. The bench model records the accepting cycle and derives from the expected outcome the single cycle in which rsp_done must be high. It also derives the run of cycles in which bus_lock must be high and req_ready low. Every falling edge is compared against those expectations, so a pulse that comes early, comes late or lasts too long is caught. After each request completes, the memory word is compared with the model's copy, which shows whether the write happened and which byte lanes it touched.

// File: rtl/cas_pkg.sv
`timescale 1ns/1ps
package cas_pkg;
    localparam logic [4:0] IDX_SP  = 5'd31;
    localparam logic [4:0] RT2_REQ = 5'h1f;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_CMP  = 2'd2,
        ST_WR   = 2'd3
    } cas_st_e;
endpackage

// File: rtl/cas_decode.sv
`timescale 1ns/1ps
// Request legality and ordering-flag decode, evaluated in the accepting cycle.
module cas_decode
    import cas_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 64,
    parameter int LANE_W   = 32,
    parameter int SP_ALIGN = 16
) (
    input  logic [1:0]        size,
    input  logic              acq_bit,
    input  logic              rel_bit,
    input  logic [4:0]        rs,
    input  logic [4:0]        rn,
    input  logic [4:0]        rt2,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sp_chk_en,
    output logic              fault,
    output logic              is_wide,
    output logic              acquire,
    output logic              rel_o,
    output logic              tagchk
);
    logic [ADDR_W-1:0] nat_mask;
    logic [ADDR_W-1:0] sp_mask;
    logic              bad_enc;
    logic              misaligned;
    logic              sp_bad;
    logic              base_is_sp;

    assign base_is_sp = (rn == IDX_SP);
    assign is_wide    = (size == 2'b11);
    assign nat_mask   = is_wide ? ADDR_W'(DATA_W/8 - 1) : ADDR_W'(LANE_W/8 - 1);
    assign sp_mask    = ADDR_W'(SP_ALIGN - 1);

    assign bad_enc    = (rt2 != RT2_REQ) || !size[1];
    assign misaligned = |(addr & nat_mask);
    assign sp_bad     = base_is_sp && sp_chk_en && (|(addr & sp_mask));
    assign fault      = bad_enc || misaligned || sp_bad;

    assign acquire    = acq_bit && (rs != IDX_SP);
    assign rel_o      = rel_bit;
    assign tagchk     = !base_is_sp;
endmodule

// File: rtl/cas_lane.sv
`timescale 1ns/1ps
// Lane selection, comparison and write packing for the memory word.
module cas_lane #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 32,
    localparam int LANES   = DATA_W / LANE_W,
    localparam int LSEL_W  = $clog2(LANES),
    localparam int LBYTES  = LANE_W / 8
) (
    input  logic              is_wide,
    input  logic [LSEL_W-1:0] lane,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] cmp,
    input  logic [DATA_W-1:0] nval,
    output logic [DATA_W-1:0] old_ext,
    output logic              match,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W/8-1:0] wmask
);
    logic [LANE_W-1:0] lane_data [LANES];
    logic [LANE_W-1:0] narrow;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_data[g]                 = rdata[g*LANE_W +: LANE_W];
        assign wmask[g*LBYTES +: LBYTES]    = (is_wide || lane == LSEL_W'(g)) ? '1 : '0;
        assign wdata[g*LANE_W +: LANE_W]    = is_wide ? nval[g*LANE_W +: LANE_W]
                                                      : nval[LANE_W-1:0];
    end

    assign narrow  = lane_data[lane];
    assign old_ext = is_wide ? rdata : DATA_W'(narrow);
    assign match   = is_wide ? (rdata == cmp) : (narrow == cmp[LANE_W-1:0]);
endmodule

// File: rtl/cas_unit.sv
`timescale 1ns/1ps
// Atomic compare-and-swap sequencer: read, compare, conditional write under lock.
module cas_unit
    import cas_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 64,
    parameter int LANE_W   = 32,
    parameter int SP_ALIGN = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [1:0]                            req_size,
    input  logic                                  req_acq_bit,
    input  logic                                  req_rel_bit,
    input  logic [4:0]                            req_rs,
    input  logic [4:0]                            req_rn,
    input  logic [4:0]                            req_rt2,
    input  logic [ADDR_W-1:0]                     req_addr,
    input  logic                                  req_sp_chk,
    input  logic [DATA_W-1:0]                     req_cmp,
    input  logic [DATA_W-1:0]                     req_new,
    output logic                                  mem_req,
    output logic                                  mem_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    mem_addr,
    output logic [DATA_W-1:0]                     mem_wdata,
    output logic [DATA_W/8-1:0]                   mem_wmask,
    input  logic [DATA_W-1:0]                     mem_rdata,
    output logic                                  bus_lock,
    output logic                                  rsp_done,
    output logic                                  rsp_abort,
    output logic                                  rsp_we,
    output logic [4:0]                            rsp_reg,
    output logic [DATA_W-1:0]                     rsp_data,
    output logic                                  rsp_acquire,
    output logic                                  rsp_release,
    output logic                                  rsp_tagchk
);
    localparam int OFF_W   = $clog2(DATA_W/8);
    localparam int LOFF_W  = $clog2(LANE_W/8);
    localparam int WADDR_W = ADDR_W - OFF_W;
    localparam int LANES   = DATA_W / LANE_W;
    localparam int LSEL_W  = $clog2(LANES);

    typedef struct packed {
        cas_st_e             st;
        logic                wide;
        logic                acq;
        logic                rel;
        logic                tag;
        logic [4:0]          rs;
        logic [LSEL_W-1:0]   lane;
        logic [WADDR_W-1:0]  waddr;
        logic [DATA_W-1:0]   cmp;
        logic [DATA_W-1:0]   nval;
        logic                done;
        logic                abort;
        logic                we;
        logic [DATA_W-1:0]   data;
    } cas_state_t;

    cas_state_t q, d;

    logic              dec_fault;
    logic              dec_wide;
    logic              dec_acq;
    logic              dec_rel;
    logic              dec_tag;
    logic [DATA_W-1:0] ln_old;
    logic              ln_match;
    logic [DATA_W-1:0] ln_wdata;
    logic [DATA_W/8-1:0] ln_wmask;

    cas_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .LANE_W   (LANE_W),
        .SP_ALIGN (SP_ALIGN)
    ) u_decode (
        .size      (req_size),
        .acq_bit   (req_acq_bit),
        .rel_bit   (req_rel_bit),
        .rs        (req_rs),
        .rn        (req_rn),
        .rt2       (req_rt2),
        .addr      (req_addr),
        .sp_chk_en (req_sp_chk),
        .fault     (dec_fault),
        .is_wide   (dec_wide),
        .acquire   (dec_acq),
        .rel_o     (dec_rel),
        .tagchk    (dec_tag)
    );

    cas_lane #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_lane (
        .is_wide (q.wide),
        .lane    (q.lane),
        .rdata   (mem_rdata),
        .cmp     (q.cmp),
        .nval    (q.nval),
        .old_ext (ln_old),
        .match   (ln_match),
        .wdata   (ln_wdata),
        .wmask   (ln_wmask)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wide  = dec_wide;
                    d.acq   = dec_acq;
                    d.rel   = dec_rel;
                    d.tag   = dec_tag;
                    d.rs    = req_rs;
                    d.lane  = req_addr[OFF_W-1:LOFF_W];
                    d.waddr = req_addr[ADDR_W-1:OFF_W];
                    d.cmp   = req_cmp;
                    d.nval  = req_new;
                    d.we    = 1'b0;
                    d.data  = '0;
                    d.abort = dec_fault;
                    if (dec_fault) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.st   = ST_RD;
                    end
                end
            end
            ST_RD: begin
                d.st = ST_CMP;
            end
            ST_CMP: begin
                d.data = ln_old;
                d.we   = 1'b1;
                if (ln_match) begin
                    d.st = ST_WR;
                end else begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            ST_WR: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign bus_lock    = (q.st != ST_IDLE);
    assign mem_req     = (q.st == ST_RD) || (q.st == ST_WR);
    assign mem_we      = (q.st == ST_WR);
    assign mem_addr    = q.waddr;
    assign mem_wdata   = ln_wdata;
    assign mem_wmask   = ln_wmask;

    assign rsp_done    = q.done;
    assign rsp_abort   = q.done && q.abort;
    assign rsp_we      = q.done && q.we;
    assign rsp_reg     = q.rs;
    assign rsp_data    = q.data;
    assign rsp_acquire = q.acq;
    assign rsp_release = q.rel;
    assign rsp_tagchk  = q.tag;
endmodule

// File: rtl/cas_unit_chk.sv
`timescale 1ns/1ps
module cas_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [4:0] req_rt2,
    input logic       mem_req,
    input logic       mem_we,
    input logic       bus_lock,
    input logic       rsp_done,
    input logic       rsp_abort,
    input logic       rsp_we,
    input logic [4:0] rsp_reg,
    input logic       rsp_acquire
);
    // R7
    lock_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> bus_lock);

    // R7
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> !req_ready);

    // R4
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_req && !mem_we, 2) && bus_lock));

    // R10
    abort_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> !rsp_we);

    // R10
    abort_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> !$past(mem_req));

    // R8
    acq_zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_reg == 5'd31) |-> !rsp_acquire);

    // R12
    rt2_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_rt2 != 5'h1f) |=> (rsp_done && rsp_abort));
endmodule

bind cas_unit cas_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_rt2     (req_rt2),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .bus_lock    (bus_lock),
    .rsp_done    (rsp_done),
    .rsp_abort   (rsp_abort),
    .rsp_we      (rsp_we),
    .rsp_reg     (rsp_reg),
    .rsp_acquire (rsp_acquire)
);

// File: tb/tb_cas_unit.sv
`timescale 1ns/1ps
module tb_cas_unit;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_size = '0;
    logic        req_acq_bit = 1'b0;
    logic        req_rel_bit = 1'b0;
    logic [4:0]  req_rs = '0;
    logic [4:0]  req_rn = '0;
    logic [4:0]  req_rt2 = '0;
    logic [15:0] req_addr = '0;
    logic        req_sp_chk = 1'b0;
    logic [63:0] req_cmp = '0;
    logic [63:0] req_new = '0;
    logic        mem_req;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_wmask;
    logic [63:0] mem_rdata = '0;
    logic        bus_lock;
    logic        rsp_done;
    logic        rsp_abort;
    logic        rsp_we;
    logic [4:0]  rsp_reg;
    logic [63:0] rsp_data;
    logic        rsp_acquire;
    logic        rsp_release;
    logic        rsp_tagchk;

    always #(CLK_P/2) clk = ~clk;

    cas_unit #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_acq_bit(req_acq_bit), .req_rel_bit(req_rel_bit),
        .req_rs(req_rs), .req_rn(req_rn), .req_rt2(req_rt2), .req_addr(req_addr),
        .req_sp_chk(req_sp_chk), .req_cmp(req_cmp), .req_new(req_new),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wmask(mem_wmask), .mem_rdata(mem_rdata), .bus_lock(bus_lock),
        .rsp_done(rsp_done), .rsp_abort(rsp_abort), .rsp_we(rsp_we), .rsp_reg(rsp_reg),
        .rsp_data(rsp_data), .rsp_acquire(rsp_acquire), .rsp_release(rsp_release),
        .rsp_tagchk(rsp_tagchk)
    );

    // Environment memory, driven by the unit's port.
    logic [63:0] bmem    [0:63];
    logic [63:0] ref_mem [0:63];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 8; b++)
                    if (mem_wmask[b]) bmem[mem_addr[5:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end else begin
                mem_rdata <= bmem[mem_addr[5:0]];
            end
        end
    end

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int acc = 0;
    int exp_at = -1;
    bit started = 1'b0;

    logic        e_abort, e_we, e_acq, e_rel, e_tag;
    logic [4:0]  e_reg;
    logic [63:0] e_data;
    string       e_tag_s = "";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model's schedule.
    always @(negedge clk) begin
        if (started) begin
            automatic bit exp_done = (cyc == exp_at);
            automatic bit exp_lock = (cyc >= acc) && (cyc < exp_at);
            chk(rsp_done == exp_done, e_tag_s, "rsp_done timing (R4 R5 R10)", 64'(rsp_done), 64'(exp_done));
            chk(bus_lock == exp_lock, "R7", "bus_lock", 64'(bus_lock), 64'(exp_lock));
            chk(req_ready == !exp_lock, "R7", "req_ready", 64'(req_ready), 64'(!exp_lock));
            if (exp_done) begin
                chk(rsp_abort == e_abort, e_tag_s, "rsp_abort", 64'(rsp_abort), 64'(e_abort));
                chk(rsp_we == e_we, e_tag_s, "rsp_we (R6)", 64'(rsp_we), 64'(e_we));
                chk(rsp_data == e_data, e_tag_s, "rsp_data (R6)", rsp_data, e_data);
                if (!e_abort) chk(rsp_reg == e_reg, "R6", "rsp_reg", 64'(rsp_reg), 64'(e_reg));
                chk(rsp_acquire == e_acq, "R8", "rsp_acquire", 64'(rsp_acquire), 64'(e_acq));
                chk(rsp_release == e_rel, "R8", "rsp_release", 64'(rsp_release), 64'(e_rel));
                chk(rsp_tagchk == e_tag, "R9", "rsp_tagchk", 64'(rsp_tagchk), 64'(e_tag));
            end
        end
    end

    task automatic run(input logic [1:0] sz, input logic lb, input logic ob,
                       input logic [4:0] rs, input logic [4:0] rn, input logic [4:0] rt2,
                       input logic [63:0] cmp, input logic [63:0] nv,
                       input int addr, input logic spc, input string tag);
        automatic bit fault;
        automatic bit wide = (sz == 2'b11);
        automatic bit hi   = (addr % 8) == 4;
        automatic int idx  = addr / 8;
        automatic logic [63:0] word = ref_mem[idx];
        automatic logic [63:0] old;
        automatic bit match;
        automatic int lat;
        fault = (rt2 != 5'h1f) || (sz < 2) || (wide ? (addr % 8) != 0 : (addr % 4) != 0)
                || (rn == 5'd31 && spc && (addr % 16) != 0);
        old   = wide ? word : (hi ? {32'h0, word[63:32]} : {32'h0, word[31:0]});
        match = wide ? (old == cmp) : (old[31:0] == cmp[31:0]);
        if (!fault && match) begin
            if (wide)    ref_mem[idx] = nv;
            else if (hi) ref_mem[idx][63:32] = nv[31:0];
            else         ref_mem[idx][31:0]  = nv[31:0];
        end
        lat = fault ? 0 : (match ? 3 : 2);
        @(negedge clk);
        req_valid = 1'b1; req_size = sz; req_acq_bit = lb; req_rel_bit = ob;
        req_rs = rs; req_rn = rn; req_rt2 = rt2; req_cmp = cmp; req_new = nv;
        req_addr = 16'(addr); req_sp_chk = spc;
        @(posedge clk);
        #1;
        e_abort = fault; e_we = !fault; e_data = fault ? 64'h0 : old; e_reg = rs;
        e_acq = lb && (rs != 5'd31); e_rel = ob; e_tag = (rn != 5'd31); e_tag_s = tag;
        acc = cyc; exp_at = cyc + lat;
        @(negedge clk);
        req_valid = 1'b0;
        while (cyc <= exp_at) @(negedge clk);
        chk(bmem[idx] == ref_mem[idx], tag, "memory word after request", bmem[idx], ref_mem[idx]);
    endtask

    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            bmem[i]    = {32'(i) * 32'h01010101, ~(32'(i) * 32'h10203040)};
            ref_mem[i] = bmem[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_done == 1'b0, "R1", "rsp_done after reset", 64'(rsp_done), 64'd0);
        chk(bus_lock == 1'b0, "R1", "bus_lock after reset", 64'(bus_lock), 64'd0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", 64'(mem_req), 64'd0);
        started = 1'b1;

        // R2 R4: 64-bit match, then same location again with the stale compare
        run(2'b11, 0, 0, 5'd3, 5'd5, 5'h1f, ref_mem[2], 64'hDEAD_BEEF_0123_4567, 16, 0, "R4");
        run(2'b11, 0, 0, 5'd3, 5'd5, 5'h1f, 64'h0, 64'h1, 16, 0, "R5");
        // R5: 64-bit mismatch
        run(2'b11, 0, 0, 5'd4, 5'd6, 5'h1f, ref_mem[3] ^ 64'h1, 64'h55, 24, 0, "R5");
        // R3: 32-bit low lane, compare upper bits ignored, upper half untouched
        run(2'b10, 0, 0, 5'd8, 5'd1, 5'h1f, {32'hFFFF_FFFF, ref_mem[4][31:0]},
            64'hAAAA_AAAA_1234_5678, 32, 0, "R3");
        // R3: 32-bit high lane match and mismatch
        run(2'b10, 0, 0, 5'd9, 5'd1, 5'h1f, {32'h0, ref_mem[5][63:32]}, 64'h0000_0000_CAFE_F00D, 44, 0, "R3");
        run(2'b10, 0, 0, 5'd9, 5'd1, 5'h1f, {32'h0, ~ref_mem[6][63:32]}, 64'h77, 52, 0, "R5");
        // R8: ordering flags
        run(2'b11, 1, 0, 5'd7, 5'd2, 5'h1f, ref_mem[7], 64'h11, 56, 0, "R8");
        run(2'b11, 1, 1, 5'd31, 5'd2, 5'h1f, 64'h0, 64'h12, 56, 0, "R8");
        run(2'b10, 0, 1, 5'd10, 5'd2, 5'h1f, 64'h0, 64'h13, 60, 0, "R8");
        // R9 R11: stack-pointer base
        run(2'b11, 0, 0, 5'd1, 5'd31, 5'h1f, ref_mem[8], 64'h99, 64, 1, "R9");
        run(2'b11, 0, 0, 5'd1, 5'd31, 5'h1f, ref_mem[9], 64'h98, 72, 1, "R11");
        run(2'b11, 0, 0, 5'd1, 5'd31, 5'h1f, ref_mem[9], 64'h97, 72, 0, "R11");
        run(2'b11, 0, 0, 5'd1, 5'd2, 5'h1f, ref_mem[9], 64'h96, 72, 1, "R11");
        // R10: misaligned accesses
        run(2'b11, 0, 0, 5'd2, 5'd3, 5'h1f, ref_mem[10], 64'h5, 84, 0, "R10");
        run(2'b10, 0, 0, 5'd2, 5'd3, 5'h1f, ref_mem[10], 64'h6, 82, 0, "R10");
        // R12: malformed encodings
        run(2'b11, 0, 0, 5'd2, 5'd3, 5'h1e, ref_mem[11], 64'h7, 88, 0, "R12");
        run(2'b01, 0, 0, 5'd2, 5'd3, 5'h1f, ref_mem[11], 64'h8, 88, 0, "R12");

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule